// File: doc/BRIEF.md
# Reconfigurable Broadcast Scan Chain

This block is a parameterised scan register of four equal segments built from mux-scan flip-flops. Each segment feeds its own scan-out pin. A one-bit mode input sets where the head of each segment takes its data from when shifting. In broadcast mode, every segment head takes the shared scan-in pin. A single serial stream therefore fills all four segments with the same data in one segment-length of shift cycles. In serial mode, the segments are linked tail to head into one chain four segments long. That mode gives full control of every cell and full observation of every cell at the last scan-out.

Scan enable picks the operation of every cell. When it is high, the cells shift. When it is low, every cell loads its functional data bit on the same edge, whatever the mode. The cell outputs go to the logic under test.

The mode input is meant to change only while scan enable is low or between patterns. A mode change in the middle of a shift is not a supported use.

Segment k (k = 0..3) owns cells k*SEG_LEN through k*SEG_LEN+SEG_LEN-1. The lowest cell of a segment is its head, and the highest cell is its tail. SEG_LEN must be at least 2.

The two head sources are named SRC_CHAIN (mode input 0) and SRC_BCAST (mode input 1). The two cell operations are named OP_CAPTURE (scan enable 0) and OP_SHIFT (scan enable 1). Each operation holds for a whole cycle, with no sequencing between operations.

Top module: `illscan_chain`

## Requirements
- R1: While rst_n is low, every cell and every scan-out bit reads 0 (asynchronous, active-low reset).
- R2: With scan_en = 0, every cell takes its func_d bit on the next rising edge, in either mode, and scan_in has no effect.
- R3: With scan_en = 1, each non-head cell of a segment takes the previous value of the cell one index below it on the next edge.
- R4: With scan_en = 1, cell 0 (the head of segment 0) takes scan_in in both modes.
- R5: With scan_en = 1 and bcast_mode = 1, the heads of segments 1 to 3 take scan_in. After SEG_LEN shifts, where bit j of a pattern is presented in shift cycle SEG_LEN-1-j, cell k*SEG_LEN+j holds bit j in every segment.
- R6: With scan_en = 1 and bcast_mode = 0, the head of segment k (k >= 1) takes the previous tail of segment k-1. After 4*SEG_LEN shifts, where bit i is presented in shift cycle 4*SEG_LEN-1-i, cell i holds bit i.
- R7: seg_out[k] always shows the tail cell of segment k. In broadcast mode, after c shifts, it shows the captured bit k*SEG_LEN+SEG_LEN-1-c.
- R8: In serial mode, a captured response leaves on seg_out[3] from cell 4*SEG_LEN-1 down to cell 0, one bit per shift, the first bit visible before any shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan and capture clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_en | input | 1 | 1 = shift, 0 = capture functional data |
| bcast_mode | input | 1 | 1 = broadcast to all segment heads, 0 = segments in series |
| scan_in | input | 1 | Shared serial scan input |
| func_d | input | 4*SEG_LEN | Functional data to the cells, bit i to cell i |
| cell_q | output | 4*SEG_LEN | Cell contents driven to the logic under test |
| seg_out | output | 4 | Tail cell of each segment, bit k for segment k |

## Verification
A capture or a single shift changes cell_q one rising edge after the inputs that cause it. The bench therefore drives inputs on the falling edge and reads the outputs on the following falling edge. A broadcast load is compared after exactly SEG_LEN shift edges, and a serial load after exactly 4*SEG_LEN shift edges.

The scan-outs come straight from the tail flops. During an unload, each seg_out value is read on the falling edge before the shift edge that replaces it. This means the first captured bit is checked with no shift at all.

// File: rtl/illscan_pkg.sv
package illscan_pkg;
    localparam int unsigned NUM_SEG = 4;

    typedef enum logic {
        SRC_CHAIN = 1'b0,
        SRC_BCAST = 1'b1
    } head_src_e;

    typedef enum logic {
        OP_CAPTURE = 1'b0,
        OP_SHIFT   = 1'b1
    } cell_op_e;
endpackage

// File: rtl/illscan_head_sel.sv
module illscan_head_sel
    import illscan_pkg::*;
(
    input  head_src_e src,
    input  logic      scan_in,
    input  logic      prev_tail,
    output logic      head
);
    always_comb begin
        unique case (src)
            SRC_BCAST: head = scan_in;
            SRC_CHAIN: head = prev_tail;
        endcase
    end
endmodule

// File: rtl/illscan_segment.sv
module illscan_segment
    import illscan_pkg::*;
#(
    parameter int unsigned SEG_LEN = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  cell_op_e           op,
    input  logic               head_in,
    input  logic [SEG_LEN-1:0] func_d,
    output logic [SEG_LEN-1:0] q,
    output logic               tail
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            unique case (op)
                OP_SHIFT:   q <= {q[SEG_LEN-2:0], head_in};
                OP_CAPTURE: q <= func_d;
            endcase
        end
    end

    assign tail = q[SEG_LEN-1];
endmodule

// File: rtl/illscan_chain.sv
module illscan_chain
    import illscan_pkg::*;
#(
    parameter int unsigned SEG_LEN = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         scan_en,
    input  logic                         bcast_mode,
    input  logic                         scan_in,
    input  logic [NUM_SEG*SEG_LEN-1:0]   func_d,
    output logic [NUM_SEG*SEG_LEN-1:0]   cell_q,
    output logic [NUM_SEG-1:0]           seg_out
);
    localparam int unsigned CELLS = NUM_SEG * SEG_LEN;

    cell_op_e            op;
    head_src_e           src;
    logic [NUM_SEG-1:0]  head;
    logic [NUM_SEG-1:0]  tail;

    assign op  = cell_op_e'(scan_en);
    assign src = head_src_e'(bcast_mode);

    assign head[0] = scan_in;

    for (genvar k = 0; k < NUM_SEG; k++) begin : g_seg
        if (k > 0) begin : g_sel
            illscan_head_sel sel_i (
                .src       (src),
                .scan_in   (scan_in),
                .prev_tail (tail[k-1]),
                .head      (head[k])
            );
        end

        illscan_segment #(.SEG_LEN(SEG_LEN)) seg_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .op      (op),
            .head_in (head[k]),
            .func_d  (func_d[k*SEG_LEN +: SEG_LEN]),
            .q       (cell_q[k*SEG_LEN +: SEG_LEN]),
            .tail    (tail[k])
        );
    end

    assign seg_out = tail;

    if (CELLS < 2*NUM_SEG) begin : g_len_check
        $error("SEG_LEN must be at least 2");
    end
endmodule

// File: rtl/illscan_chk.sv
module illscan_chk
    import illscan_pkg::*;
#(
    parameter int unsigned SEG_LEN = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       scan_en,
    input logic                       bcast_mode,
    input logic                       scan_in,
    input logic [NUM_SEG*SEG_LEN-1:0] func_d,
    input logic [NUM_SEG*SEG_LEN-1:0] cell_q,
    input logic [NUM_SEG-1:0]         seg_out
);
    // R1: reset holds everything at zero
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (cell_q == '0 && seg_out == '0));

    // R2: capture loads functional data in any mode
    a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_en |=> cell_q == $past(func_d));

    // R4: segment 0 head always follows scan_in
    a_r4_head0: assert property (@(posedge clk) disable iff (!rst_n)
        scan_en |=> cell_q[0] == $past(scan_in));

    for (genvar k = 0; k < NUM_SEG; k++) begin : g_k
        // R3: shift inside each segment
        a_r3_shift_body: assert property (@(posedge clk) disable iff (!rst_n)
            scan_en |=> cell_q[k*SEG_LEN+1 +: SEG_LEN-1]
                        == $past(cell_q[k*SEG_LEN +: SEG_LEN-1]));
        if (k > 0) begin : g_head
            // R5: broadcast heads take scan_in
            a_r5_bcast_head: assert property (@(posedge clk) disable iff (!rst_n)
                (scan_en && bcast_mode) |=> cell_q[k*SEG_LEN] == $past(scan_in));
            // R6: serial heads take the previous segment tail
            a_r6_serial_head: assert property (@(posedge clk) disable iff (!rst_n)
                (scan_en && !bcast_mode) |=> cell_q[k*SEG_LEN] == $past(seg_out[k-1]));
        end
    end
endmodule

bind illscan_chain illscan_chk #(.SEG_LEN(SEG_LEN)) chk_i (.*);

// File: tb/illscan_chain_tb.sv
module illscan_chain_tb_top;
    localparam int unsigned L = 8;
    localparam int unsigned N = 4 * L;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           scan_en = 1'b0;
    logic           bcast_mode = 1'b0;
    logic           scan_in = 1'b0;
    logic [N-1:0]   func_d = '0;
    logic [N-1:0]   cell_q;
    logic [3:0]     seg_out;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    illscan_chain #(.SEG_LEN(L)) dut_i (
        .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .bcast_mode(bcast_mode),
        .scan_in(scan_in), .func_d(func_d), .cell_q(cell_q), .seg_out(seg_out)
    );

    // {bcast, stimulus, expected cell_q}
    localparam logic [64:0] VECS [0:5] = '{
        {1'b0, 32'hA5C30F96, 32'hA5C30F96},
        {1'b0, 32'h00000001, 32'h00000001},
        {1'b0, 32'h80000000, 32'h80000000},
        {1'b1, 32'h00000096, 32'h96969696},
        {1'b1, 32'h00000001, 32'h01010101},
        {1'b1, 32'h000000F0, 32'hF0F0F0F0}
    };

    task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic shift_in(input logic bc, input logic [N-1:0] stim, input int n);
        bcast_mode = bc;
        scan_en = 1'b1;
        for (int c = 0; c < n; c++) begin
            scan_in = stim[n-1-c];
            tick();
        end
    endtask

    task automatic capture(input logic [N-1:0] val);
        scan_en = 1'b0;
        func_d = val;
        tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] st;
        logic [N-1:0] ex;
        logic [N-1:0] cap;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 cells", cell_q, '0);
        chk("R1 seg_out", {28'd0, seg_out}, '0);
        rst_n = 1'b1;
        tick();

        // R5 / R6: table of loads
        for (int v = 0; v < 6; v++) begin
            shift_in(VECS[v][64], VECS[v][63:32], VECS[v][64] ? L : N);
            chk(VECS[v][64] ? "R5 broadcast load" : "R6 serial load", cell_q, VECS[v][31:0]);
            ex = VECS[v][31:0];
            chk("R7 tails", {28'd0, seg_out}, {28'd0, ex[31], ex[23], ex[15], ex[7]});
        end

        // R2: capture in both modes, scan_in ignored
        bcast_mode = 1'b1; scan_in = 1'b1;
        capture(32'h1234ABCD);
        chk("R2 capture bcast", cell_q, 32'h1234ABCD);
        bcast_mode = 1'b0;
        capture(32'hFEDC0123);
        chk("R2 capture serial", cell_q, 32'hFEDC0123);

        // R3 / R4: one serial shift
        st = cell_q;
        shift_in(1'b0, 32'h1, 1);
        chk("R3 R4 serial single shift", cell_q, {st[N-2:0], 1'b1});

        // R3 / R5: one broadcast shift with zero
        st = cell_q;
        for (int k = 0; k < 4; k++) ex[k*L +: L] = {st[k*L +: L-1], 1'b0};
        shift_in(1'b1, 32'h0, 1);
        chk("R3 R5 broadcast single shift", cell_q, ex);

        // R8: serial unload
        cap = 32'hDEADBEEF;
        capture(cap);
        bcast_mode = 1'b0; scan_en = 1'b1; scan_in = 1'b0;
        for (int c = 0; c < N; c++) begin
            chk("R8 serial unload", {31'd0, seg_out[3]}, {31'd0, cap[N-1-c]});
            tick();
        end
        chk("R6 chain flushed", cell_q, '0);

        // R7: broadcast unload on every scan-out
        cap = 32'h5A3CF00F;
        capture(cap);
        bcast_mode = 1'b1; scan_en = 1'b1; scan_in = 1'b0;
        for (int c = 0; c < L; c++) begin
            chk("R7 broadcast unload", {28'd0, seg_out},
                {28'd0, cap[31-c], cap[23-c], cap[15-c], cap[7-c]});
            tick();
        end
        scan_en = 1'b0;

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule